// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up by generating the sequence of control words that an SDRAM controller's timing/control register would receive. When started, it captures a timing configuration word and a bank configuration word. From these it works out the mode-register data, either from an explicit override field or from the CAS latency, clock-speed and bus-width settings. It then presents an initialization word with refresh held off and waits out the power-up delay.

After the delay it walks a fixed list of twenty command codes. Each code is merged into the initialization word, and each command is held for a fixed minimum gap. The pass ends with a restore word that re-enables normal refresh and drops the mode data. The whole pass runs twice. Each new control word is flagged by a one-cycle strobe. A done flag rises with the final restore word and stays high until the next accepted start.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `ctrlWord` is 0, `wordValid` is 0 and `done` is 0.
- R2: If bits 23:16 of the captured timing word are nonzero, those bits are the mode-register data.
- R3: Otherwise the mode-register data is derived as follows.
  - Timing bit 12 set selects the fast clock. At the fast clock a CAS field (bits 1:0) of 0 means CAS latency 2. At the slow clock a CAS field of 1 means CAS latency 2. Every other value means CAS latency 3.
  - The data is 0x40 for latency 2 and 0x60 for latency 3.
  - The data is halved when bank-configuration bit 23 is clear (16-bit bus), giving 0x20 or 0x30.
- R4: The first word of a pass is the initialization word. It is built from the timing word in these steps:
  - AND the timing word with 0x8000F9FF.
  - Set bit 31.
  - Set bits 15:14 to 11.
  - Place the mode-register data in bits 23:16.
- R5: The first command word appears exactly `CLK_MHZ*DELAY_US` cycles after the initialization word (minimum 2).
- R6: The commands, in order, are:
  - 3 (precharge), then 0.
  - Eight pairs of 2 (refresh) and 0.
  - 1 (mode set), then 0.

  Each word is the initialization word OR-ed with the code placed in bits 10:9.
- R7: Consecutive command words, and the last command word and the restore word, are exactly `max(CMD_GAP,5)` cycles apart.
- R8: Each pass ends with the restore word, which is the timing word AND 0x8000F9FF with bit 31 set. The second pass's initialization word follows one cycle later. A run presents exactly 44 words.
- R9: `done` rises together with the second restore word. It then stays high, and no further words appear, until a start is accepted.
- R10: `start` is ignored while a run is in progress. The configuration inputs are sampled only in the cycle a start is accepted.
- R11: A `start` seen while idle begins a new run and clears `done` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| timingIn | input | 32 | Timing configuration word |
| bankIn | input | 32 | Bank configuration word (bit 23 = 32-bit bus) |
| ctrlWord | output | 32 | Control word for the SDRAM controller |
| wordValid | output | 1 | One-cycle strobe marking each newly presented word |
| done | output | 1 | High after both passes have completed |

## Verification
The hardest situation to reach is a start request arriving while a run is in progress. It must be ignored, and the configuration inputs must be changed at that moment to prove they are not recaptured. The stimulus starts a run and waits until the sequencer is inside the power-up delay. It then changes both configuration words and pulses start again. The full 44-word log is then compared against the first configuration, including every spacing between words.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int CMD_COUNT = 20;
  localparam int IDX_W     = $clog2(CMD_COUNT);

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_WAIT, S_CMD, S_GAP, S_RESTORE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadCfg;
    logic       emitInit;
    logic       emitCmd;
    logic       emitRestore;
    logic [1:0] cmdCode;
  } dpCtl_t;

  // command list: precharge, nop, 8x (refresh, nop), mode set, nop
  function automatic logic [1:0] cmdAt(input logic [IDX_W-1:0] idx);
    if (idx == IDX_W'(0))       return 2'd3;
    else if (idx == IDX_W'(18)) return 2'd1;
    else if (idx[0])            return 2'd0;
    else                        return 2'd2;
  endfunction

endpackage

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] timingIn,
  input  logic [31:0] bankIn,
  input  dpCtl_t      ctl,
  output logic [31:0] ctrlWord,
  output logic        wordValid
);

  localparam logic [31:0] KEEP_MASK  = 32'h8000_F9FF;
  localparam logic [31:0] ENABLE_BIT = 32'h8000_0000;
  localparam logic [31:0] REFR_OFF   = 32'h0000_C000;

  logic [31:0] timingReg, bankReg;
  logic [7:0]  mrsData;
  logic        fastClk, casLat2;
  logic [31:0] restoreWord, initWord, cmdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timingReg <= '0;
      bankReg   <= '0;
    end else if (ctl.loadCfg) begin
      timingReg <= timingIn;
      bankReg   <= bankIn;
    end
  end

  always_comb begin
    fastClk = timingReg[12];
    casLat2 = fastClk ? (timingReg[1:0] == 2'd0) : (timingReg[1:0] == 2'd1);
    if (timingReg[23:16] != 8'h00) begin
      mrsData = timingReg[23:16];
    end else begin
      mrsData = casLat2 ? 8'h40 : 8'h60;
      if (!bankReg[23]) mrsData = mrsData >> 1;
    end
  end

  assign restoreWord = (timingReg & KEEP_MASK) | ENABLE_BIT;
  assign initWord    = restoreWord | REFR_OFF | {8'h00, mrsData, 16'h0000};
  assign cmdWord     = initWord | {21'd0, ctl.cmdCode, 9'd0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= ctl.emitInit | ctl.emitCmd | ctl.emitRestore;
      if (ctl.emitInit)         ctrlWord <= initWord;
      else if (ctl.emitCmd)     ctrlWord <= cmdWord;
      else if (ctl.emitRestore) ctrlWord <= restoreWord;
    end
  end

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int DELAY_EFF  = 20000,
  parameter int GAP_EFF    = 5,
  parameter int NUM_PASSES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output dpCtl_t ctl,
  output logic   done
);

  localparam int CNT_MAX = (DELAY_EFF > GAP_EFF) ? DELAY_EFF : GAP_EFF;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PASS_W  = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [PASS_W-1:0] pass;

  always_comb begin
    ctl = '0;
    case (state)
      S_IDLE:    ctl.loadCfg     = start;
      S_INIT:    ctl.emitInit    = 1'b1;
      S_CMD: begin
        ctl.emitCmd = 1'b1;
        ctl.cmdCode = cmdAt(idx);
      end
      S_RESTORE: ctl.emitRestore = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      pass  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done  <= 1'b0;
          pass  <= '0;
          idx   <= '0;
          state <= S_INIT;
        end
        S_INIT: begin
          cnt   <= CNT_W'(DELAY_EFF - 2);
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_CMD;
          else           cnt   <= cnt - 1'b1;
        end
        S_CMD: begin
          cnt   <= CNT_W'(GAP_EFF - 2);
          state <= S_GAP;
        end
        S_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (idx == IDX_W'(CMD_COUNT - 1)) begin
            state <= S_RESTORE;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_CMD;
          end
        end
        S_RESTORE: begin
          idx <= '0;
          if (pass == PASS_W'(NUM_PASSES - 1)) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            pass  <= pass + 1'b1;
            state <= S_INIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int DELAY_US   = 200,
  parameter int CMD_GAP    = 5,
  parameter int NUM_PASSES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] timingIn,
  input  logic [31:0] bankIn,
  output logic [31:0] ctrlWord,
  output logic        wordValid,
  output logic        done
);

  localparam int DELAY_RAW = CLK_MHZ * DELAY_US;
  localparam int DELAY_EFF = (DELAY_RAW < 2) ? 2 : DELAY_RAW;
  localparam int GAP_EFF   = (CMD_GAP < 5) ? 5 : CMD_GAP;

  dpCtl_t ctl;

  sdram_init_ctrl #(
    .DELAY_EFF (DELAY_EFF),
    .GAP_EFF   (GAP_EFF),
    .NUM_PASSES(NUM_PASSES)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .done (done)
  );

  sdram_init_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .timingIn (timingIn),
    .bankIn   (bankIn),
    .ctl      (ctl),
    .ctrlWord (ctrlWord),
    .wordValid(wordValid)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int GAP = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] ctrlWord,
  input logic        wordValid,
  input logic        done
);

  logic [15:0] sinceLast;

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceLast <= 16'hFFFF;
    else if (wordValid)         sinceLast <= 16'd1;
    else if (sinceLast != 16'hFFFF) sinceLast <= sinceLast + 16'd1;
  end

  // R4: every presented word has the enable bit
  p_enable_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ctrlWord[31]);

  // R6: a nonzero command only rides on a refresh-off word
  p_cmd_refresh_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && ctrlWord[10:9] != 2'b00) |-> ctrlWord[15:14] == 2'b11);

  // R7: nonzero commands never come sooner than the gap
  p_min_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && ctrlWord[10:9] != 2'b00) |-> sinceLast >= 16'(GAP));

  // R7: the word only changes with a strobe
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(ctrlWord));

  // R9: done persists until a start is seen
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R9: no words while done is held
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> !wordValid);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.GAP(GAP_EFF)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .ctrlWord (ctrlWord),
  .wordValid(wordValid),
  .done     (done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int CLK_MHZ  = 1;
  localparam int DELAY_US = 40;
  localparam int CMD_GAP  = 6;
  localparam int DELAY    = CLK_MHZ * DELAY_US;
  localparam int WORDS    = 44;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] timingIn = '0;
  logic [31:0] bankIn = '0;
  logic [31:0] ctrlWord;
  logic        wordValid;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  int cycle   = 0;
  logic [31:0] logW [0:63];
  int          logT [0:63];
  int          logN = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .DELAY_US(DELAY_US), .CMD_GAP(CMD_GAP), .NUM_PASSES(2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .timingIn(timingIn),
    .bankIn(bankIn), .ctrlWord(ctrlWord), .wordValid(wordValid), .done(done)
  );

  always @(negedge clk) begin
    cycle <= cycle + 1;
    if (rstN && wordValid && logN < 64) begin
      logW[logN] = ctrlWord;
      logT[logN] = cycle;
      logN = logN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expCode(input int i);
    if (i == 0)  return 2'd3;
    if (i == 18) return 2'd1;
    if (i % 2)   return 2'd0;
    return 2'd2;
  endfunction

  task automatic startRun(input logic [31:0] t, input logic [31:0] b);
    logN = 0;
    @(negedge clk);
    timingIn = t; bankIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkLog(input logic [31:0] t, input logic [7:0] mrs, input string tag);
    logic [31:0] rest, init;
    rest = (t & 32'h8000F9FF) | 32'h80000000;
    init = rest | 32'h0000C000 | {8'h00, mrs, 16'h0000};
    check(logN == WORDS, {tag, " R8 word count"}, 32'(logN), 32'(WORDS));
    if (logN != WORDS) return;
    for (int p = 0; p < 2; p++) begin
      int base = p * 22;
      check(logW[base] == init, {tag, " R4/R2/R3 init word"}, logW[base], init);
      check(logT[base+1] - logT[base] == DELAY, {tag, " R5 delay"},
            32'(logT[base+1] - logT[base]), 32'(DELAY));
      for (int i = 0; i < 20; i++) begin
        logic [31:0] e;
        e = init | {21'd0, expCode(i), 9'd0};
        check(logW[base+1+i] == e, {tag, " R6 command word"}, logW[base+1+i], e);
        check(logT[base+2+i] - logT[base+1+i] == CMD_GAP, {tag, " R7 gap"},
              32'(logT[base+2+i] - logT[base+1+i]), 32'(CMD_GAP));
      end
      check(logW[base+21] == rest, {tag, " R8 restore word"}, logW[base+21], rest);
      if (p == 0)
        check(logT[22] - logT[21] == 1, {tag, " R8 second pass follows"},
              32'(logT[22] - logT[21]), 32'd1);
    end
  endtask

  task automatic runAndCheck(input logic [31:0] t, input logic [31:0] b,
                             input logic [7:0] mrs, input string tag);
    startRun(t, b);
    waitDone();
    repeat (3) @(negedge clk);
    checkLog(t, mrs, tag);
  endtask

  task automatic testReset();
    check(ctrlWord == 32'h0, "R1 ctrlWord in reset", ctrlWord, 32'h0);
    check(!wordValid && !done, "R1 strobe/done in reset",
          {30'd0, wordValid, done}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(ctrlWord == 32'h0 && !wordValid && !done, "R1 after reset",
          ctrlWord, 32'h0);
  endtask

  task automatic testBusyStart();
    logic [31:0] t1;
    t1 = 32'h0000_1001;
    startRun(t1, 32'h0080_0000);
    repeat (10) @(negedge clk);
    timingIn = 32'h00AB_0000; bankIn = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10 done low during run", {31'd0, done}, 32'h0);
    waitDone();
    repeat (3) @(negedge clk);
    checkLog(t1, 8'h60, "busy-start R10");
  endtask

  task automatic testDoneHold();
    int n0;
    n0 = logN;
    repeat (30) @(negedge clk);
    check(done == 1'b1, "R9 done held", {31'd0, done}, 32'h1);
    check(logN == n0, "R9 no words after done", 32'(logN), 32'(n0));
    logN = 0;
    @(negedge clk); timingIn = 32'h0000_1000; bankIn = 32'h0080_0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R11 start clears done", {31'd0, done}, 32'h0);
    waitDone();
    repeat (3) @(negedge clk);
    checkLog(32'h0000_1000, 8'h40, "rearm R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    runAndCheck(32'h0000_1000, 32'h0080_0000, 8'h40, "fast cas0 32b R3");
    runAndCheck(32'h0000_1001, 32'h0080_0000, 8'h60, "fast cas1 32b R3");
    runAndCheck(32'h0000_0001, 32'h0000_0000, 8'h20, "slow cas1 16b R3");
    runAndCheck(32'h0000_0002, 32'h0000_0000, 8'h30, "slow cas2 16b R3");
    runAndCheck(32'h3A5A_36FE, 32'h0000_0000, 8'h5A, "override R2");
    testBusyStart();
    testDoneHold();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule